// File: doc/BRIEF.md
# Striped ALU Array with Early Exit Taps

This block is a two-dimensional compute array. Each horizontal stripe holds W cells, and each cell ends in a register. The stripes are stacked H deep. The first stripe reads its operands from the array's top input word, and every later stripe reads the registered results of the stripe above it. Most cells are small ALUs whose two operand multiplexers can pick any column of the stripe above. A fixed, evenly spread subset of columns holds dedicated vertical pass cells instead. Such a cell can only copy the value directly above it, or it can stay idle and keep its register unchanged.

Results do not have to travel to the bottom. Exit taps are placed after every EXIT_EVERY-th stripe, and the last stripe is always a tap. A result can leave at the first tap below the stripe that produced it. Behind each tap, a plain register delay line aligns the tapped stripe with the bottom of the array. Every fabric output therefore carries a sample's result exactly H clock edges after that sample entered, whichever tap it came from. Each output has its own selection of tap and column.

All cell and output settings are loaded one word at a time through an address and write-enable port before streaming starts. Any configuration write discards every sample that is still in flight.

Top module: `fab_stripe_array`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `out_data` is all zero. Every cell configuration resets to op 0 (idle), and every output select resets to tap 0, column 0.
- R2: A write with `cfg_we`=1 stores `cfg_data` at address `s*W+c` as the word of the cell in stripe s, column c. The fields of a cell word are op in bits [2:0], operand-A column in [2+CW:3] and operand-B column in [2+2CW:3+CW]. Address `H*W+j` stores the select for output j, with the column in bits [CW-1:0] and the tap index in [CW+TW-1:CW].
- R3: The op codes of an ALU cell are 1 A+B, 2 A-B, 3 A&B, 4 A|B, 5 A^B, 6 A and 7 B. A and B are the columns named in the cell word, taken from the stripe above, or from `in_data` (column c at bits [c*DW +: DW]) for stripe 0.
- R4: Column c is a dedicated pass column when `c % PASS_PERIOD == PASS_PERIOD-1`. In such a column, any nonzero op copies the same column of the stripe above, and the operand fields are ignored.
- R5: Op 0 leaves a cell idle. An idle cell, whether ALU or pass cell, keeps its registered value, and it resumes when given a nonzero op.
- R6: Tap k reads stripe min((k+1)*EXIT_EVERY-1, H-1), so the last stripe is always a tap. A tap index at or above the tap count selects the last tap.
- R7: For a sample presented with `in_valid`=1, `out_valid` is 1 exactly H rising edges later and 0 one edge earlier. `out_data` holds that sample's result, whichever tap is selected.
- R8: Output j drives `out_data[j*DW +: DW]` from the selected column of the selected tap.
- R9: A cycle with `cfg_we`=1 clears every in-flight valid bit, including that of a sample presented in the same cycle, so none of those samples ever raises `out_valid`.
- R10: Samples on consecutive cycles come out on consecutive cycles, in order.
- R11: Arithmetic wraps modulo 2^DW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a sample on in_data |
| in_data | input | W*DW | Top-edge operands, one DW column per cell of stripe 0 |
| cfg_we | input | 1 | Configuration write strobe; also flushes in-flight samples |
| cfg_addr | input | AW | Cell index or output-select index |
| cfg_data | input | CFG_W | Configuration word |
| out_valid | output | 1 | Marks a result on out_data |
| out_data | output | NOUT*DW | Selected results, DW bits per output |

## Verification
The bench uses the default parameters: four columns, six stripes, a tap after every second stripe, a pass period of three and two outputs. This gives three taps, the last being the bottom stripe, and column 2 is a dedicated pass column. Those values let the bench compare an early tap against the bottom tap at the same latency, route operands across columns in a middle stripe, and idle a pass cell and an ALU cell side by side. They also let it flush samples both in flight and on the very cycle they enter.

// File: rtl/fab_pkg.sv
package fab_pkg;

    localparam int OP_BITS = 3;

    typedef enum logic [OP_BITS-1:0] {
        OP_IDLE   = 3'd0,
        OP_ADD    = 3'd1,
        OP_SUB    = 3'd2,
        OP_AND    = 3'd3,
        OP_OR     = 3'd4,
        OP_XOR    = 3'd5,
        OP_PASS_A = 3'd6,
        OP_PASS_B = 3'd7
    } fab_op_e;

    // Number of exit taps for a given spacing and height.
    function automatic int tap_count(int every, int h);
        return (h + every - 1) / every;
    endfunction

    // Stripe index read by tap k; the last stripe closes the list.
    function automatic int tap_stripe(int k, int every, int h);
        int r;
        r = (k + 1) * every - 1;
        return (r > h - 1) ? h - 1 : r;
    endfunction

    // True when column c carries a dedicated vertical pass cell.
    function automatic bit is_pass_col(int c, int period);
        return (period > 0) && ((c % period) == period - 1);
    endfunction

endpackage

// File: rtl/fab_cell.sv
module fab_cell
    import fab_pkg::*;
#(
    parameter int DW      = 8,
    parameter int W       = 4,
    parameter int CW      = 2,
    parameter int COL     = 0,
    parameter bit IS_PASS = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_BITS-1:0]  op,
    input  logic [CW-1:0]       sel_a,
    input  logic [CW-1:0]       sel_b,
    input  logic [W*DW-1:0]     src,
    output logic [DW-1:0]       q
);

    logic [DW-1:0] nxt;
    logic          hold;

    assign hold = (op == OP_IDLE);

    generate
        if (IS_PASS) begin : g_pass
            // Vertical copy only; operand selects have no meaning here.
            logic unused_pass;
            assign unused_pass = ^{sel_a, sel_b, src};
            assign nxt = src[COL*DW +: DW];
        end else begin : g_alu
            logic [DW-1:0] opa;
            logic [DW-1:0] opb;
            assign opa = src[sel_a*DW +: DW];
            assign opb = src[sel_b*DW +: DW];
            always_comb begin
                unique case (fab_op_e'(op))
                    OP_IDLE:   nxt = opa;
                    OP_ADD:    nxt = opa + opb;
                    OP_SUB:    nxt = opa - opb;
                    OP_AND:    nxt = opa & opb;
                    OP_OR:     nxt = opa | opb;
                    OP_XOR:    nxt = opa ^ opb;
                    OP_PASS_A: nxt = opa;
                    OP_PASS_B: nxt = opb;
                    default:   nxt = opa;
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!hold) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/fab_cfg_store.sv
module fab_cfg_store
    import fab_pkg::*;
#(
    parameter int W     = 4,
    parameter int H     = 6,
    parameter int NOUT  = 2,
    parameter int CW    = 2,
    parameter int TW    = 2,
    parameter int AW    = 5,
    parameter int CFG_W = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [AW-1:0]                   addr,
    input  logic [CFG_W-1:0]                data,
    output logic [H*W-1:0][OP_BITS-1:0]     cell_op,
    output logic [H*W-1:0][CW-1:0]          cell_sa,
    output logic [H*W-1:0][CW-1:0]          cell_sb,
    output logic [NOUT-1:0][TW-1:0]         out_tap,
    output logic [NOUT-1:0][CW-1:0]         out_col
);

    localparam int NCELL = H * W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_op <= '0;
            cell_sa <= '0;
            cell_sb <= '0;
            out_tap <= '0;
            out_col <= '0;
        end else if (we) begin
            for (int i = 0; i < NCELL; i++) begin
                if (addr == AW'(i)) begin
                    cell_op[i] <= data[OP_BITS-1:0];
                    cell_sa[i] <= data[OP_BITS +: CW];
                    cell_sb[i] <= data[OP_BITS+CW +: CW];
                end
            end
            for (int j = 0; j < NOUT; j++) begin
                if (addr == AW'(NCELL + j)) begin
                    out_col[j] <= data[CW-1:0];
                    out_tap[j] <= data[CW +: TW];
                end
            end
        end
    end

endmodule

// File: rtl/fab_exit_delay.sv
module fab_exit_delay #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_wire
            logic unused_ck;
            assign unused_ck = clk ^ rst_n;
            assign q = d;
        end else begin : g_reg
            logic [DEPTH-1:0][WIDTH-1:0] stg;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < DEPTH; i++) begin
                        stg[i] <= stg[i-1];
                    end
                end
            end
            assign q = stg[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/fab_out_sel.sv
module fab_out_sel #(
    parameter int DW   = 8,
    parameter int W    = 4,
    parameter int NTAP = 3,
    parameter int NOUT = 2,
    parameter int CW   = 2,
    parameter int TW   = 2
) (
    input  logic [NTAP-1:0][W*DW-1:0] taps,
    input  logic [NOUT-1:0][TW-1:0]   out_tap,
    input  logic [NOUT-1:0][CW-1:0]   out_col,
    output logic [NOUT*DW-1:0]        out_data
);

    generate
        for (genvar j = 0; j < NOUT; j++) begin : g_out
            logic [W*DW-1:0] row;
            always_comb begin
                if (int'(out_tap[j]) < NTAP) begin
                    row = taps[out_tap[j]];
                end else begin
                    row = taps[NTAP-1];
                end
            end
            assign out_data[j*DW +: DW] = row[out_col[j]*DW +: DW];
        end
    endgenerate

endmodule

// File: rtl/fab_stripe_array.sv
module fab_stripe_array
    import fab_pkg::*;
#(
    parameter int DW          = 8,
    parameter int W           = 4,
    parameter int H           = 6,
    parameter int EXIT_EVERY  = 2,
    parameter int PASS_PERIOD = 3,
    parameter int NOUT        = 2,
    localparam int CW    = (W > 1) ? $clog2(W) : 1,
    localparam int NTAP  = tap_count(EXIT_EVERY, H),
    localparam int TW    = (NTAP > 1) ? $clog2(NTAP) : 1,
    localparam int AW    = $clog2(H*W + NOUT),
    localparam int CFG_W = OP_BITS + 2*CW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [W*DW-1:0]      in_data,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [CFG_W-1:0]     cfg_data,
    output logic                 out_valid,
    output logic [NOUT*DW-1:0]   out_data
);

    logic [H*W-1:0][OP_BITS-1:0] cell_op;
    logic [H*W-1:0][CW-1:0]      cell_sa;
    logic [H*W-1:0][CW-1:0]      cell_sb;
    logic [NOUT-1:0][TW-1:0]     out_tap;
    logic [NOUT-1:0][CW-1:0]     out_col;

    logic [H-1:0][W*DW-1:0]      row_src;
    logic [H-1:0][W*DW-1:0]      row_q;
    logic [NTAP-1:0][W*DW-1:0]   tap_al;
    logic [H-1:0]                vld_q;

    fab_cfg_store #(
        .W(W), .H(H), .NOUT(NOUT), .CW(CW), .TW(TW), .AW(AW), .CFG_W(CFG_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .data    (cfg_data),
        .cell_op (cell_op),
        .cell_sa (cell_sa),
        .cell_sb (cell_sb),
        .out_tap (out_tap),
        .out_col (out_col)
    );

    generate
        for (genvar s = 0; s < H; s++) begin : g_stripe
            if (s == 0) begin : g_top
                assign row_src[s] = in_data;
            end else begin : g_below
                assign row_src[s] = row_q[s-1];
            end
            for (genvar c = 0; c < W; c++) begin : g_col
                fab_cell #(
                    .DW(DW), .W(W), .CW(CW), .COL(c),
                    .IS_PASS(is_pass_col(c, PASS_PERIOD))
                ) u_cell (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .op    (cell_op[s*W + c]),
                    .sel_a (cell_sa[s*W + c]),
                    .sel_b (cell_sb[s*W + c]),
                    .src   (row_src[s]),
                    .q     (row_q[s][c*DW +: DW])
                );
            end
        end

        for (genvar k = 0; k < NTAP; k++) begin : g_tap
            localparam int TS = tap_stripe(k, EXIT_EVERY, H);
            fab_exit_delay #(
                .WIDTH(W*DW), .DEPTH(H - 1 - TS)
            ) u_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (row_q[TS]),
                .q     (tap_al[k])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (cfg_we) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= in_valid;
            for (int i = 1; i < H; i++) begin
                vld_q[i] <= vld_q[i-1];
            end
        end
    end

    assign out_valid = vld_q[H-1];

    fab_out_sel #(
        .DW(DW), .W(W), .NTAP(NTAP), .NOUT(NOUT), .CW(CW), .TW(TW)
    ) u_sel (
        .taps     (tap_al),
        .out_tap  (out_tap),
        .out_col  (out_col),
        .out_data (out_data)
    );

endmodule

// File: rtl/fab_stripe_array_chk.sv
module fab_stripe_array_chk
    import fab_pkg::*;
#(
    parameter int DW          = 8,
    parameter int W           = 4,
    parameter int H           = 6,
    parameter int PASS_PERIOD = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_we,
    input logic                         out_valid,
    input logic [W*DW-1:0]              in_data,
    input logic [H-1:0][W*DW-1:0]       row_q,
    input logic [H*W-1:0][OP_BITS-1:0]  op_q
);

    localparam int CNT_W = $clog2(H + 1);

    logic [CNT_W-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (cfg_we) begin
            since_q <= '0;
        end else if (since_q < CNT_W'(H)) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R9
    flush_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !out_valid);

    // R7
    min_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_q >= CNT_W'(H)));

    generate
        for (genvar s = 0; s < H; s++) begin : g_s
            for (genvar c = 0; c < W; c++) begin : g_c
                // R5
                idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (op_q[s*W + c] == OP_IDLE) |=> $stable(row_q[s][c*DW +: DW]));
                if (is_pass_col(c, PASS_PERIOD)) begin : g_p
                    if (s == 0) begin : g_first
                        // R4
                        pass_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
                            (op_q[c] != OP_IDLE) |=>
                            (row_q[0][c*DW +: DW] == $past(in_data[c*DW +: DW])));
                    end else begin : g_rest
                        // R4
                        pass_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
                            (op_q[s*W + c] != OP_IDLE) |=>
                            (row_q[s][c*DW +: DW] == $past(row_q[s-1][c*DW +: DW])));
                    end
                end
            end
        end
    endgenerate

endmodule

bind fab_stripe_array fab_stripe_array_chk #(
    .DW(DW), .W(W), .H(H), .PASS_PERIOD(PASS_PERIOD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .out_valid (out_valid),
    .in_data   (in_data),
    .row_q     (row_q),
    .op_q      (cell_op)
);

// File: tb/sim_fab_stripe_array.sv
module sim_fab_stripe_array;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int W  = 4;
    localparam int H  = 6;
    localparam int NOUT = 2;
    localparam int OUTBASE = H * W;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_data;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [6:0]  cfg_data;
    logic        out_valid;
    logic [15:0] out_data;

    int n_chk;
    int n_fail;
    bit done;

    fab_stripe_array #(
        .DW(DW), .W(W), .H(H), .EXIT_EVERY(2), .PASS_PERIOD(3), .NOUT(NOUT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [6:0] cw(input int op, input int sa, input int sb);
        return {sb[1:0], sa[1:0], op[2:0]};
    endfunction

    function automatic logic [6:0] ow(input int tap, input int col);
        return {3'b000, tap[1:0], col[1:0]};
    endfunction

    function automatic logic [31:0] pack(input int a, input int b, input int c, input int d);
        return {d[7:0], c[7:0], b[7:0], a[7:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int addr, input logic [6:0] data);
        cfg_we   = 1'b1;
        cfg_addr = addr[4:0];
        cfg_data = data;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    // Present one sample, check valid timing and both outputs (R7).
    task automatic run_one(input logic [31:0] vec, input logic [7:0] e0,
                           input logic [7:0] e1, input string tag);
        in_valid = 1'b1;
        in_data  = vec;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (H - 2) @(negedge clk);
        chk({tag, " R7 valid low one edge early"}, {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk({tag, " R7 valid after H edges"}, {31'd0, out_valid}, 32'd1);
        chk({tag, " out0"}, {24'd0, out_data[7:0]}, {24'd0, e0});
        chk({tag, " out1"}, {24'd0, out_data[15:8]}, {24'd0, e1});
        @(negedge clk);
        chk({tag, " R7 single valid"}, {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset data", {16'd0, out_data}, 32'd0);
    endtask

    task automatic t_basic();
        // stripe 0 ops, lower stripes copy straight down
        cfg_write(0, cw(1, 0, 1));
        cfg_write(1, cw(2, 0, 1));
        cfg_write(2, cw(6, 0, 0));
        cfg_write(3, cw(5, 2, 3));
        for (int s = 1; s < H; s++) begin
            for (int c = 0; c < W; c++) begin
                cfg_write(s*W + c, cw(6, c, c));
            end
        end
        cfg_write(OUTBASE + 0, ow(0, 0));
        cfg_write(OUTBASE + 1, ow(2, 3));
        // R2 R3 R6 R8: early tap ADD versus bottom tap XOR
        run_one(pack(10, 3, 8'h5a, 8'h0f), 8'd13, 8'h55, "R6 R8 basic");
    endtask

    task automatic t_wrap();
        cfg_write(OUTBASE + 0, ow(1, 1));
        cfg_write(OUTBASE + 1, ow(0, 0));
        // R11: 100-200 and 100+200 wrap
        run_one(pack(100, 200, 0, 0), 8'd156, 8'd44, "R11 wrap");
    endtask

    task automatic t_stream();
        in_valid = 1'b1;
        in_data = pack(1, 2, 0, 0);   @(negedge clk);
        in_data = pack(50, 7, 0, 0);  @(negedge clk);
        in_data = pack(255, 1, 0, 0); @(negedge clk);
        in_valid = 1'b0;
        repeat (H - 3) @(negedge clk);
        chk("R10 stream v0", {31'd0, out_valid}, 32'd1);
        chk("R10 stream d0", {16'd0, out_data}, {16'd0, 8'd3, 8'd255});
        @(negedge clk);
        chk("R10 stream v1", {31'd0, out_valid}, 32'd1);
        chk("R10 stream d1", {16'd0, out_data}, {16'd0, 8'd57, 8'd43});
        @(negedge clk);
        chk("R10 stream v2", {31'd0, out_valid}, 32'd1);
        chk("R10 stream d2", {16'd0, out_data}, {16'd0, 8'd0, 8'd254});
        @(negedge clk);
        chk("R10 stream end", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_pass();
        // R4: operand fields on a pass cell are ignored
        cfg_write(3*W + 2, cw(6, 1, 3));
        cfg_write(OUTBASE + 1, ow(2, 2));
        run_one(pack(9, 4, 8'h77, 8'h01), 8'd5, 8'h77, "R4 pass column");
    endtask

    task automatic t_ops();
        cfg_write(0, cw(3, 0, 1));
        cfg_write(1, cw(4, 0, 1));
        cfg_write(3, cw(7, 0, 1));
        cfg_write(OUTBASE + 0, ow(1, 0));
        cfg_write(OUTBASE + 1, ow(2, 3));
        run_one(pack(8'hcc, 8'haa, 0, 0), 8'h88, 8'haa, "R3 and passb");
        // R6: out-of-range tap index falls back to bottom tap
        cfg_write(OUTBASE + 0, ow(0, 1));
        cfg_write(OUTBASE + 1, ow(3, 3));
        run_one(pack(8'hcc, 8'haa, 0, 0), 8'hee, 8'haa, "R3 R6 or tapclamp");
    endtask

    task automatic t_cross();
        cfg_write(0, cw(1, 0, 1));
        cfg_write(3, cw(5, 2, 3));
        cfg_write(2*W + 1, cw(1, 0, 3));
        cfg_write(OUTBASE + 0, ow(1, 1));
        cfg_write(OUTBASE + 1, ow(0, 3));
        // R3: (5+6) + (f0^0c) = 0x107 -> 0x07
        run_one(pack(5, 6, 8'hf0, 8'h0c), 8'h07, 8'hfc, "R3 cross column");
    endtask

    task automatic t_idle();
        // held values come from last sample 0xf0 / 0x0c
        cfg_write(1*W + 2, cw(0, 0, 0));
        cfg_write(1*W + 3, cw(0, 0, 0));
        cfg_write(OUTBASE + 0, ow(2, 2));
        cfg_write(OUTBASE + 1, ow(2, 3));
        run_one(pack(1, 2, 8'h11, 8'h22), 8'hf0, 8'hfc, "R5 idle hold");
        cfg_write(1*W + 2, cw(6, 2, 2));
        cfg_write(1*W + 3, cw(6, 3, 3));
        run_one(pack(1, 2, 8'h11, 8'h22), 8'h11, 8'h33, "R5 resume");
    endtask

    task automatic t_flush();
        bit seen;
        in_valid = 1'b1;
        in_data  = pack(3, 4, 5, 6);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        cfg_write(OUTBASE + 0, ow(2, 2));
        seen = 1'b0;
        for (int i = 0; i < H + 2; i++) begin
            if (out_valid) seen = 1'b1;
            @(negedge clk);
        end
        chk("R9 in-flight flushed", {31'd0, seen}, 32'd0);
        // sample and write in the same cycle
        in_valid = 1'b1;
        cfg_we   = 1'b1;
        cfg_addr = 5'(OUTBASE + 0);
        cfg_data = ow(2, 2);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_we   = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < H + 2; i++) begin
            if (out_valid) seen = 1'b1;
            @(negedge clk);
        end
        chk("R9 same-cycle flushed", {31'd0, seen}, 32'd0);
        // R9: array still works afterwards
        run_one(pack(3, 4, 8'h5c, 8'h06), 8'h5c, 8'h5a, "R9 after flush");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        n_chk = 0;
        n_fail = 0;
        done = 1'b0;
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_data = '0;
        cfg_we = 1'b0;
        cfg_addr = '0;
        cfg_data = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_stream();
        t_pass();
        t_ops();
        t_cross();
        t_idle();
        t_flush();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule